// File: doc/BRIEF.md
# Handset Power-Enable Controller

This block decides whether a battery handset's main supply switch is closed. Three wake sources can turn it on: a keypad power key, a general-purpose auxiliary switch input, and a one-cycle alarm pulse from a real-time clock. Each wake event is latched as a flag in a status register, and a flag stays set until software writes a 1 to its bit. While any flag is set, the block drives a power-enable output high and its inverse low. It also raises a hardware-control interrupt. That interrupt reaches a shared combined-interrupt pin only when software has enabled it.

The key input, the auxiliary input and the active-low low-battery input pass through long debouncers. These debouncers are clocked by a slow tick enable, nominally 32.768 kHz. The auxiliary input acts on its debounced rising edge only. When the battery is reported low, or the active-low reset-out input is asserted, switch-on is blocked: power-enable is held low and the combined-interrupt pin is released (output enable low). Software turns the handset off by writing a power-off command once every wake flag has been cleared.

Top module: `pwr_ctl_top`

## Requirements
- R1: The key, auxiliary and low-battery inputs are each debounced. A debounced value changes only after the synchronised input has differed from it for DB_TICKS consecutive ticks. A pulse shorter than that has no effect on the flags or the power state.
- R2: A debounced key rising edge sets flag bit 0. A debounced auxiliary rising edge sets bit 1. An alarm pulse sets bit 2. The flag appears one clock after the event.
- R3: When no inhibit is present, power_en is high in the same cycle that any flag is visible. It then stays high until a valid power-off.
- R4: Writing address 0 with a 1 in bit i clears flag i. Writing 0 to a bit leaves that flag unchanged. A set event in the same cycle as a clear wins.
- R5: Reading address 0 returns the flags in bits 2:0 and, in bit 3, a 1 while the debounced battery state is low. Reading address 1 returns the interrupt enable in bit 0.
- R6: comb_irq is high only while some flag is set, the enable (address 1, bit 0) is 1 and no inhibit is present. A hardware reset clears the enable.
- R7: While the debounced low-battery input is low, or rstout_n is low, power_en is low and comb_irq_oe is low.
- R8: Writing address 2 with bit 0 set while no flag is set drops power_en at the next clock. The same write while a flag is set is ignored.
- R9: An auxiliary input that stays high after its flag is cleared does not set the flag again.
- R10: power_en_n is always the inverse of power_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| tick_en | input | 1 | Slow tick enable for the debouncers |
| key_in | input | 1 | Power key, active high |
| aux_in | input | 1 | Auxiliary switch, rising-edge sensitive |
| alarm_pulse | input | 1 | Alarm-match pulse from the clock block |
| lowbat_n_in | input | 1 | Low-battery indication, active low |
| rstout_n | input | 1 | Reset-out, active low, blocks switch-on |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| power_en | output | 1 | Main power enable |
| power_en_n | output | 1 | Inverse of power_en |
| comb_irq | output | 1 | Combined-interrupt line value |
| comb_irq_oe | output | 1 | Output enable of the combined-interrupt line |

## Verification
The three debounced inputs pass through a two-flop synchroniser and then need DB_TICKS ticks. The flag register adds one more clock. A wake flag therefore appears DB_TICKS+3 clocks after the key or auxiliary input changes, and one clock after an alarm pulse. The power, interrupt and read-data outputs follow the flags combinationally. Register writes, and the power-off command, take effect at the next clock. The reset-out inhibit acts at once. The bench drives inputs on falling edges and waits a margin past each latency before it queues its expectations. The monitor compares results a fixed delay after the same falling edge, so every comparison sees settled values.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
  localparam int NUM_SRC   = 3;
  localparam int SRC_KEY   = 0;
  localparam int SRC_AUX   = 1;
  localparam int SRC_ALARM = 2;

  localparam logic [1:0] ADDR_FLAGS = 2'd0;
  localparam logic [1:0] ADDR_IRQEN = 2'd1;
  localparam logic [1:0] ADDR_CMD   = 2'd2;

  typedef logic [NUM_SRC-1:0] wake_vec_t;
endpackage

// File: rtl/pwr_debounce.sv
module pwr_debounce #(
  parameter int DB_TICKS = 2048,
  parameter bit RST_VAL  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic din,
  output logic dout
);
  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= {2{RST_VAL}};
    else        sync_q <= {sync_q[0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dout  <= RST_VAL;
    end else if (sync_q[1] == dout) begin
      cnt_q <= '0;
    end else if (tick_en) begin
      if (cnt_q == LAST) begin
        dout  <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_wake_flags.sv
module pwr_wake_flags import pwr_ctl_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      key_db,
  input  logic      aux_db,
  input  logic      alarm,
  input  wake_vec_t clr_vec,
  output wake_vec_t flags
);
  logic      key_d, aux_d;
  wake_vec_t set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_d <= 1'b0;
      aux_d <= 1'b0;
    end else begin
      key_d <= key_db;
      aux_d <= aux_db;
    end
  end

  always_comb begin
    set_vec            = '0;
    set_vec[SRC_KEY]   = key_db & ~key_d;
    set_vec[SRC_AUX]   = aux_db & ~aux_d;
    set_vec[SRC_ALARM] = alarm;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_regs.sv
module pwr_regs import pwr_ctl_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  wake_vec_t     flags,
  input  logic          bat_low,
  output wake_vec_t     clr_vec,
  output logic          irq_en,
  output logic          off_req,
  output logic [DW-1:0] reg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  irq_en <= 1'b0;
    else if (reg_wr && reg_addr == ADDR_IRQEN)   irq_en <= reg_wdata[0];
  end

  assign clr_vec = (reg_wr && reg_addr == ADDR_FLAGS) ? reg_wdata[NUM_SRC-1:0] : '0;
  assign off_req = reg_wr && (reg_addr == ADDR_CMD) && reg_wdata[0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_FLAGS: begin
        reg_rdata[NUM_SRC-1:0] = flags;
        reg_rdata[NUM_SRC]     = bat_low;
      end
      ADDR_IRQEN: reg_rdata[0] = irq_en;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwr_ctl_top.sv
module pwr_ctl_top import pwr_ctl_pkg::*; #(
  parameter int DB_TICKS = 2048,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          key_in,
  input  logic          aux_in,
  input  logic          alarm_pulse,
  input  logic          lowbat_n_in,
  input  logic          rstout_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          power_en,
  output logic          power_en_n,
  output logic          comb_irq,
  output logic          comb_irq_oe
);
  localparam int NDB = 3;
  localparam logic [NDB-1:0] DB_RST = 3'b100;

  logic [NDB-1:0] raw_vec, db_vec;
  wake_vec_t      flags, clr_vec;
  logic           irq_en, off_req, inhibit, lowbat_db_n, pwr_on_q, any_flag;

  assign raw_vec = {lowbat_n_in, aux_in, key_in};

  for (genvar i = 0; i < NDB; i++) begin : g_db
    pwr_debounce #(.DB_TICKS(DB_TICKS), .RST_VAL(DB_RST[i])) u_db (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .din(raw_vec[i]), .dout(db_vec[i])
    );
  end

  assign lowbat_db_n = db_vec[2];

  pwr_wake_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .key_db(db_vec[0]), .aux_db(db_vec[1]), .alarm(alarm_pulse),
    .clr_vec(clr_vec), .flags(flags)
  );

  pwr_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flags(flags), .bat_low(~lowbat_db_n),
    .clr_vec(clr_vec), .irq_en(irq_en), .off_req(off_req),
    .reg_rdata(reg_rdata)
  );

  assign inhibit  = ~lowbat_db_n | ~rstout_n;
  assign any_flag = |flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pwr_on_q <= 1'b0;
    else if (inhibit)  pwr_on_q <= 1'b0;
    else if (any_flag) pwr_on_q <= 1'b1;
    else if (off_req)  pwr_on_q <= 1'b0;
  end

  assign power_en    = ~inhibit & (pwr_on_q | any_flag);
  assign power_en_n  = ~power_en;
  assign comb_irq_oe = ~inhibit;
  assign comb_irq    = any_flag & irq_en & ~inhibit;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk import pwr_ctl_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       rstout_n,
  input logic       alarm_pulse,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       power_en,
  input logic       power_en_n,
  input logic       comb_irq,
  input logic       comb_irq_oe,
  input wake_vec_t  flags,
  input logic       irq_en,
  input logic       lowbat_db_n
);
  AST_PWR_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
    power_en != power_en_n); // R10

  AST_RSTOUT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !rstout_n |-> (!power_en && !comb_irq_oe)); // R7

  AST_LOWBAT_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    !lowbat_db_n |-> (!power_en && !comb_irq_oe)); // R7

  AST_ALARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |=> flags[SRC_ALARM]); // R2

  AST_FLAG_POWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ((|flags) && rstout_n && lowbat_db_n) |-> power_en); // R3

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    comb_irq |-> (irq_en && (|flags) && comb_irq_oe)); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[SRC_ALARM] && !(reg_wr && reg_addr == ADDR_FLAGS && reg_wdata[SRC_ALARM]))
      |=> flags[SRC_ALARM]); // R4
endmodule

bind pwr_ctl_top pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rstout_n(rstout_n), .alarm_pulse(alarm_pulse),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .power_en(power_en), .power_en_n(power_en_n),
  .comb_irq(comb_irq), .comb_irq_oe(comb_irq_oe),
  .flags(flags), .irq_en(irq_en), .lowbat_db_n(lowbat_db_n)
);

// File: tb/pwr_ctl_top_tb.sv
`timescale 1ns/1ps
module pwr_ctl_top_tb;
  localparam int DBT  = 16;
  localparam int SETL = DBT + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b1;
  logic key_in = 1'b0, aux_in = 1'b0, alarm_pulse = 1'b0;
  logic lowbat_n_in = 1'b1, rstout_n = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic power_en, power_en_n, comb_irq, comb_irq_oe;

  always #4 clk = ~clk;

  pwr_ctl_top #(.DB_TICKS(DBT), .DW(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .key_in(key_in), .aux_in(aux_in), .alarm_pulse(alarm_pulse),
    .lowbat_n_in(lowbat_n_in), .rstout_n(rstout_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .power_en(power_en), .power_en_n(power_en_n),
    .comb_irq(comb_irq), .comb_irq_oe(comb_irq_oe)
  );

  typedef struct {
    string      tag;
    int         sel;
    logic [7:0] exp;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // Driver side: inputs change on the falling edge; expectations are queued 1 ns later.
  task automatic push_exp(string tag, int sel, logic [7:0] exp);
    exp_t it;
    #1;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  // sel 1 packs {comb_irq_oe, comb_irq, power_en_n, power_en}
  task automatic exp_status(string tag, logic [3:0] v);
    @(negedge clk);
    push_exp(tag, 1, {4'd0, v});
  endtask

  task automatic exp_read(string tag, logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    push_exp(tag, 0, v);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_alarm();
    @(negedge clk);
    alarm_pulse = 1'b1;
    @(negedge clk);
    alarm_pulse = 1'b0;
  endtask

  // Monitor: pops queued expectations 2 ns after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = (it.sel == 0) ? reg_rdata
                            : {4'd0, comb_irq_oe, comb_irq, power_en_n, power_en};
        total++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    @(negedge clk); rst_n = 1'b1;
    exp_status("R10 reset outputs", 4'b1010);
    exp_read("R5 reset flags", 2'd0, 8'h00);
    exp_read("R6 reset enable", 2'd1, 8'h00);

    // R1: short key glitch is filtered out
    @(negedge clk); key_in = 1'b1;
    wait_cyc(5);
    key_in = 1'b0;
    wait_cyc(SETL);
    exp_read("R1 glitch ignored flags", 2'd0, 8'h00);
    exp_status("R1 glitch ignored power", 4'b1010);

    // R2/R3: debounced key press powers on
    @(negedge clk); key_in = 1'b1;
    wait_cyc(SETL);
    exp_read("R2 key flag", 2'd0, 8'h01);
    exp_status("R3 power on, irq masked", 4'b1001);

    // R6: enabling the interrupt drives the shared line
    wr(2'd1, 8'h01);
    exp_read("R6 enable readback", 2'd1, 8'h01);
    exp_status("R6 irq enabled", 4'b1101);

    // R4: write 0 leaves flag, write 1 clears it
    wr(2'd0, 8'h00);
    exp_read("R4 write zero keeps flag", 2'd0, 8'h01);
    wr(2'd0, 8'h01);
    exp_read("R4 write one clears flag", 2'd0, 8'h00);
    exp_status("R3 power held after clear", 4'b1001);

    // R8: power-off with no flags
    wr(2'd2, 8'h01);
    exp_status("R8 power off accepted", 4'b1010);
    @(negedge clk); key_in = 1'b0;
    wait_cyc(SETL);

    // R2/R8: alarm wakes; power-off refused while flag set
    pulse_alarm();
    exp_read("R2 alarm flag", 2'd0, 8'h04);
    exp_status("R3 alarm powers on", 4'b1101);
    wr(2'd2, 8'h01);
    exp_status("R8 power off refused", 4'b1101);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h01);
    exp_status("R8 power off after clear", 4'b1010);

    // R9: aux edge sets once; held level does not re-set
    @(negedge clk); aux_in = 1'b1;
    wait_cyc(SETL);
    exp_read("R2 aux flag", 2'd0, 8'h02);
    wr(2'd0, 8'h02);
    wait_cyc(SETL);
    exp_read("R9 aux held no re-set", 2'd0, 8'h00);
    wr(2'd2, 8'h01);
    exp_status("R9 power down with aux high", 4'b1010);

    // R7: low battery inhibits
    @(negedge clk); lowbat_n_in = 1'b0;
    wait_cyc(SETL);
    exp_read("R5 battery low bit", 2'd0, 8'h08);
    exp_status("R7 lowbat idle", 4'b0010);
    pulse_alarm();
    exp_read("R7 flag set while inhibited", 2'd0, 8'h0C);
    exp_status("R7 lowbat blocks power", 4'b0010);
    @(negedge clk); lowbat_n_in = 1'b1;
    wait_cyc(SETL);
    exp_status("R7 lowbat released", 4'b1101);
    @(negedge clk); rstout_n = 1'b0;
    exp_status("R7 rstout blocks power", 4'b0010);
    @(negedge clk); rstout_n = 1'b1;
    wr(2'd0, 8'h04);
    wr(2'd2, 8'h01);
    exp_status("R8 off after rstout", 4'b1010);

    // R6: hardware reset clears the enable
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    exp_read("R6 enable cleared by reset", 2'd1, 8'h00);

    wait_cyc(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule